// File: doc/BRIEF.md
# Shared Rotating-Weight Decimation Filter

This block turns the per-channel residue bitstreams of a bank of hybrid successive-approximation / sigma-delta converters into fine PCM samples. Every channel owns one small unsigned weight register and one signed add/subtract accumulator, and no channel has a multiplier. On reset the weight registers are loaded with a fixed window shape, one weight per channel. During every enabled residue step the weights then rotate by one position around the channel ring. As a result each channel walks through the whole window once per conversion, but each starts at a different phase of it.

During each enabled step a channel adds its current weight when its modulator bit is 1 and subtracts it when the bit is 0. After one full window (one step per channel) the accumulator is reduced to a small signed correction. That correction is appended below the coarse SAR code, the sum is saturated to the output width, and all channels present their samples together with a one-cycle valid strobe. The surrounding converter sequencer drives the residue-enable input high for the modulator cycles that follow the SAR bit cycles. A low cycle freezes the filter, so a window may be stretched.

Top module: `dsf_shared_fir`

## Requirements
- R1: While reset is asserted and after its release, before any enabled step, `pcm_valid` is 0 and every `pcm` lane is 0.
- R2: Weight index i (0-based, i < NCH) equals round(PEAK · ((1 − cos(2π(i+1)/(NCH+1)))/2)^0.7). After reset, channel c holds index c.
- R3: On the k-th enabled step of a window (k = 0 … NCH−1), channel c uses weight index (c+k) mod NCH, so the ring is back in its reset order at every window boundary.
- R4: On an enabled step, a modulator bit of 1 adds the current weight to the channel accumulator and a bit of 0 subtracts it.
- R5: The first enabled step of each window discards the previous accumulator value and starts from that step's signed term alone, so windows run back to back without carry-over.
- R6: A channel's SAR code is taken on the first enabled step of a window. Values present on later steps of that window do not affect the result.
- R7: A cycle with `res_en` low changes no weight, accumulator, step position or output, whatever the modulator bits and SAR codes are.
- R8: With SH = AW−1−EXT, each lane's result is SAR·2^EXT + clamp(floor(acc/2^SH), −2^(EXT−1), 2^(EXT−1)−1), limited to the range 0 … 2^OUT_W−1. Channel c sits in bits [c·OUT_W +: OUT_W] and SAR code c in bits [c·SAR_W +: SAR_W].
- R9: `pcm_valid` is high for exactly the one cycle after the final step of a window. `pcm` holds its value until the next window completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset; reloads the weight ring |
| res_en | input | 1 | High on residue (modulator) cycles; each high cycle is one window step |
| mod_bits | input | NCH | One sigma-delta output bit per channel |
| sar_codes | input | NCH·SAR_W | Packed coarse SAR codes, channel c at [c·SAR_W +: SAR_W] |
| pcm | output | NCH·OUT_W | Packed fine samples, channel c at [c·OUT_W +: OUT_W] |
| pcm_valid | output | 1 | One-cycle strobe after each completed window |

## Verification
The main bench instance has 8 channels, EXT = 11 and AW = 12, so the reduction shift is zero and each lane exposes its full accumulator. Every weight position, ring phase and sign decision can therefore be checked exactly: with impulse, all-ones, all-zeros and mixed bitstreams, and with paused and back-to-back windows. This small instance also brings the negative saturation to zero within reach. A second instance with the default 44-channel, 10-bit configuration is driven with constant-density streams. It confirms that, for the shipped weight set, a full-scale stream lands on the ends of the 4-bit correction range.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

   // R2: raised-cosine-like window weight, index 0-based
   function automatic int unsigned tap_weight(input int unsigned idx,
                                              input int unsigned taps,
                                              input int unsigned peak);
      real ang;
      real base;
      ang  = 2.0 * 3.14159265358979 * real'(idx + 1) / real'(taps + 1);
      base = (1.0 - $cos(ang)) / 2.0;
      return $rtoi(real'(peak) * $pow(base, 0.7) + 0.5);
   endfunction

   function automatic int unsigned tap_total(input int unsigned taps,
                                             input int unsigned peak);
      int unsigned s;
      s = 0;
      for (int unsigned i = 0; i < taps; i++) s += tap_weight(i, taps, peak);
      return s;
   endfunction

endpackage

// File: rtl/dsf_win_seq.sv
module dsf_win_seq #(
   parameter int unsigned STEPS = 44
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_en,
   output logic first_o,
   output logic last_o
);
   localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CNT_W-1:0] LAST_V = CNT_W'(STEPS - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (step_en) cnt <= (cnt == LAST_V) ? '0 : cnt + 1'b1;
   end

   assign first_o = step_en && (cnt == '0);
   assign last_o  = step_en && (cnt == LAST_V);

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST_V);
   // R7
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(cnt));
endmodule

// File: rtl/dsf_coef_ring.sv
module dsf_coef_ring
   import dsf_pkg::*;
#(
   parameter int unsigned NCH  = 44,
   parameter int unsigned CW   = 7,
   parameter int unsigned PEAK = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [NCH*CW-1:0] taps
);
   localparam int unsigned TOTAL = tap_total(NCH, PEAK);
   localparam int unsigned SUM_W = CW + $clog2(NCH + 1);

   logic [CW-1:0] ring [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_slot
      localparam int unsigned NXT = (c + 1) % NCH;
      localparam logic [CW-1:0] INIT = CW'(tap_weight(c, NCH, PEAK));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   ring[c] <= INIT;
         else if (adv) ring[c] <= ring[NXT];
      end
      assign taps[c*CW +: CW] = ring[c];
   end

   logic [SUM_W-1:0] ring_sum;
   always_comb begin
      ring_sum = '0;
      for (int i = 0; i < NCH; i++) ring_sum = ring_sum + SUM_W'(ring[i]);
   end

   // R3: rotation only permutes the weights, it never alters them
   ring_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ring_sum == SUM_W'(TOTAL));
endmodule

// File: rtl/dsf_ch_accum.sv
module dsf_ch_accum #(
   parameter int unsigned CW    = 7,
   parameter int unsigned AW    = 12,
   parameter int unsigned SAR_W = 6,
   parameter int unsigned EXT   = 4,
   parameter int unsigned OUT_W = 10,
   parameter int          LIMIT = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             first,
   input  logic             last,
   input  logic             mod_bit,
   input  logic [CW-1:0]    coef,
   input  logic [SAR_W-1:0] sar_code,
   output logic [OUT_W-1:0] pcm
);
   localparam int SH   = int'(AW) - 1 - int'(EXT);
   localparam int RMAX = (1 << (EXT - 1)) - 1;
   localparam int RMIN = -(1 << (EXT - 1));
   localparam int OMAX = (1 << OUT_W) - 1;

   logic signed [AW-1:0]      mag, term, acc, acc_nxt, scaled, resid;
   logic        [SAR_W-1:0]   sar_q, sar_sel;
   logic signed [OUT_W+1:0]   wide;
   logic        [OUT_W-1:0]   pcm_nxt;

   always_comb begin
      mag     = $signed(AW'(coef));
      term    = mod_bit ? mag : -mag;
      acc_nxt = first ? term : acc + term;
      scaled  = acc_nxt >>> SH;
      if (scaled > RMAX)      resid = AW'(RMAX);
      else if (scaled < RMIN) resid = AW'(RMIN);
      else                    resid = scaled;
      sar_sel = first ? sar_code : sar_q;
      wide    = $signed({2'b00, sar_sel, {EXT{1'b0}}}) + (OUT_W+2)'(resid);
      if (wide < 0)         pcm_nxt = '0;
      else if (wide > OMAX) pcm_nxt = '1;
      else                  pcm_nxt = OUT_W'(wide);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc   <= '0;
         sar_q <= '0;
         pcm   <= '0;
      end else if (step_en) begin
         acc <= acc_nxt;
         if (first) sar_q <= sar_code;
         if (last)  pcm   <= pcm_nxt;
      end
   end

   // R4: a window never exceeds the summed weights in either direction
   acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc <= LIMIT) && (acc >= -LIMIT));
   // R7
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(acc) && $stable(pcm));
endmodule

// File: rtl/dsf_shared_fir.sv
module dsf_shared_fir
   import dsf_pkg::*;
#(
   parameter int unsigned NCH   = 44,
   parameter int unsigned CW    = 7,
   parameter int unsigned PEAK  = 40,
   parameter int unsigned AW    = 12,
   parameter int unsigned SAR_W = 6,
   parameter int unsigned EXT   = 4,
   parameter int unsigned OUT_W = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 res_en,
   input  logic [NCH-1:0]       mod_bits,
   input  logic [NCH*SAR_W-1:0] sar_codes,
   output logic [NCH*OUT_W-1:0] pcm,
   output logic                 pcm_valid
);
   localparam int unsigned TOTAL = tap_total(NCH, PEAK);

   if (PEAK >= (1 << CW)) begin : g_bad_peak
      $error("weight peak does not fit the weight register");
   end
   if (TOTAL >= (1 << (AW - 1))) begin : g_bad_acc
      $error("accumulator too narrow for the window sum");
   end
   if (EXT == 0 || EXT > AW - 1 || CW >= AW) begin : g_bad_ext
      $error("extension width out of range");
   end
   if (OUT_W != SAR_W + EXT) begin : g_bad_out
      $error("output width must equal SAR width plus extension");
   end

   logic              first, last;
   logic [NCH*CW-1:0] taps;

   dsf_win_seq #(.STEPS(NCH)) u_seq (
      .clk(clk), .rst_n(rst_n), .step_en(res_en),
      .first_o(first), .last_o(last)
   );

   dsf_coef_ring #(.NCH(NCH), .CW(CW), .PEAK(PEAK)) u_ring (
      .clk(clk), .rst_n(rst_n), .adv(res_en), .taps(taps)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dsf_ch_accum #(
         .CW(CW), .AW(AW), .SAR_W(SAR_W), .EXT(EXT), .OUT_W(OUT_W),
         .LIMIT(int'(TOTAL))
      ) u_acc (
         .clk(clk), .rst_n(rst_n), .step_en(res_en),
         .first(first), .last(last),
         .mod_bit(mod_bits[c]),
         .coef(taps[c*CW +: CW]),
         .sar_code(sar_codes[c*SAR_W +: SAR_W]),
         .pcm(pcm[c*OUT_W +: OUT_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pcm_valid <= 1'b0;
      else        pcm_valid <= last;
   end

   // R9
   valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_valid |-> $past(res_en));
   // R9
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pcm_valid && NCH > 1) |=> !pcm_valid);
   // R9
   pcm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pcm_valid |-> $stable(pcm));
endmodule

// File: tb/dsf_shared_fir_test.sv
module dsf_shared_fir_test;
   localparam int TN = 8, TCW = 7, TPEAK = 100, TAW = 12, TSW = 3, TEXT = 11;
   localparam int TOW = TSW + TEXT;
   localparam int DN = 44, DSW = 6, DOW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic               s_en = 1'b0;
   logic [TN-1:0]      s_bits = '0;
   logic [TN*TSW-1:0]  s_sar = '0;
   logic [TN*TOW-1:0]  s_pcm;
   logic               s_vld;

   logic               d_en = 1'b0;
   logic [DN-1:0]      d_bits = '0;
   logic [DN*DSW-1:0]  d_sar = '0;
   logic [DN*DOW-1:0]  d_pcm;
   logic               d_vld;

   dsf_shared_fir #(.NCH(TN), .CW(TCW), .PEAK(TPEAK), .AW(TAW),
                    .SAR_W(TSW), .EXT(TEXT), .OUT_W(TOW)) uut (
      .clk(clk), .rst_n(rst_n), .res_en(s_en), .mod_bits(s_bits),
      .sar_codes(s_sar), .pcm(s_pcm), .pcm_valid(s_vld));

   dsf_shared_fir dflt (
      .clk(clk), .rst_n(rst_n), .res_en(d_en), .mod_bits(d_bits),
      .sar_codes(d_sar), .pcm(d_pcm), .pcm_valid(d_vld));

   int checks = 0;
   int failures = 0;
   logic [TN-1:0] pat [TN];
   int sar_v [TN];

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R2: bench-side weight formula
   function automatic int bw(input int i, input int n, input int peak);
      real a;
      a = 2.0 * 3.14159265358979 * real'(i + 1) / real'(n + 1);
      return $rtoi(real'(peak) * $pow((1.0 - $cos(a)) / 2.0, 0.7) + 0.5);
   endfunction

   // R8: output shaping
   function automatic int shape(input int acc, input int sar, input int ext,
                                input int aw, input int ow);
      int r, v;
      r = acc >>> (aw - 1 - ext);
      if (r > (1 << (ext - 1)) - 1) r = (1 << (ext - 1)) - 1;
      if (r < -(1 << (ext - 1)))    r = -(1 << (ext - 1));
      v = (sar << ext) + r;
      if (v < 0) v = 0;
      if (v > (1 << ow) - 1) v = (1 << ow) - 1;
      return v;
   endfunction

   // R3 R4: channel c, step k uses weight (c+k) mod N
   function automatic int exp_small(input int c);
      int acc;
      acc = 0;
      for (int k = 0; k < TN; k++)
         acc += pat[k][c] ? bw((c + k) % TN, TN, TPEAK) : -bw((c + k) % TN, TN, TPEAK);
      return shape(acc, sar_v[c], TEXT, TAW, TOW);
   endfunction

   task automatic run_small(input int pause_at, input bit scr_sar);
      for (int k = 0; k < TN; k++) begin
         if (k == pause_at) begin
            for (int p = 0; p < 2; p++) begin
               s_en = 1'b0; s_bits = ~pat[k]; s_sar = ~s_sar;
               @(negedge clk);
            end
         end
         s_en = 1'b1; s_bits = pat[k];
         for (int c = 0; c < TN; c++)
            s_sar[c*TSW +: TSW] = (k > 0 && scr_sar) ? TSW'(~sar_v[c]) : TSW'(sar_v[c]);
         @(negedge clk);
      end
   endtask

   task automatic check_small(input string req);
      check({req, " R9 valid"}, int'(s_vld), 1);
      for (int c = 0; c < TN; c++)
         check(req, int'(s_pcm[c*TOW +: TOW]), exp_small(c));
   endtask

   task automatic idle_small();
      logic [TN*TOW-1:0] held;
      held = s_pcm;
      s_en = 1'b0; s_bits = '1;
      @(negedge clk);
      check("R9 valid low after strobe", int'(s_vld), 0);
      check("R9 pcm held", int'(s_pcm == held), 1);
   endtask

   task automatic run_dflt(input bit ones, input int sarval);
      for (int k = 0; k < DN; k++) begin
         d_en = 1'b1; d_bits = ones ? '1 : '0;
         for (int c = 0; c < DN; c++) d_sar[c*DSW +: DSW] = DSW'(sarval);
         @(negedge clk);
      end
      d_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int dtot;
      repeat (2) @(negedge clk);
      // R1: during reset
      check("R1 valid in reset", int'(s_vld), 0);
      check("R1 pcm in reset", int'(s_pcm == '0), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after release", int'(d_vld), 0);
      check("R1 dflt pcm zero", int'(d_pcm == '0), 1);

      // R4 R8: all ones, varied SAR codes
      for (int k = 0; k < TN; k++) pat[k] = '1;
      for (int c = 0; c < TN; c++) sar_v[c] = c;
      run_small(-1, 1'b0);
      check_small("R4 all ones");
      idle_small();

      // R8: all zeros with SAR 0 saturates to zero; SAR 7 stays positive
      for (int k = 0; k < TN; k++) pat[k] = '0;
      for (int c = 0; c < TN; c++) sar_v[c] = (c < 4) ? 0 : 7;
      run_small(-1, 1'b0);
      check_small("R8 all zeros saturation");
      idle_small();

      // R2 R3: impulse at step c for channel c exposes each ring phase
      for (int k = 0; k < TN; k++)
         for (int c = 0; c < TN; c++) pat[k][c] = (k == c);
      for (int c = 0; c < TN; c++) sar_v[c] = 3;
      run_small(-1, 1'b0);
      check_small("R3 impulse phase");

      // R5: back-to-back windows, mixed patterns, no carry-over
      for (int seed = 0; seed < 3; seed++) begin
         for (int k = 0; k < TN; k++)
            for (int c = 0; c < TN; c++) pat[k][c] = (((k * 3 + c * 5 + seed * 2) % 7) < 3);
         for (int c = 0; c < TN; c++) sar_v[c] = (c + seed) % 8;
         run_small(-1, 1'b0);
         check_small("R5 back-to-back");
      end
      idle_small();

      // R7: pause mid-window with disturbing inputs
      for (int k = 0; k < TN; k++)
         for (int c = 0; c < TN; c++) pat[k][c] = ((k + c) % 3 == 0);
      for (int c = 0; c < TN; c++) sar_v[c] = 7 - c;
      run_small(3, 1'b0);
      check_small("R7 paused window");
      idle_small();

      // R6: SAR inputs scrambled after the first step
      for (int c = 0; c < TN; c++) sar_v[c] = (c * 3 + 1) % 8;
      run_small(-1, 1'b1);
      check_small("R6 SAR sampled on first step");
      idle_small();

      // R8: default 44-channel configuration at both stream extremes
      dtot = 0;
      for (int i = 0; i < DN; i++) dtot += bw(i, DN, 40);
      run_dflt(1'b1, 63);
      check("R9 dflt valid", int'(d_vld), 1);
      check("R8 dflt ones ch0", int'(d_pcm[0 +: DOW]), shape(dtot, 63, 4, 12, DOW));
      check("R8 dflt ones ch43", int'(d_pcm[43*DOW +: DOW]), shape(dtot, 63, 4, 12, DOW));
      run_dflt(1'b0, 0);
      check("R8 dflt zeros ch0", int'(d_pcm[0 +: DOW]), shape(-dtot, 0, 4, 12, DOW));
      check("R8 dflt zeros ch21", int'(d_pcm[21*DOW +: DOW]), shape(-dtot, 0, 4, 12, DOW));
      run_dflt(1'b0, 20);
      check("R8 dflt zeros sar20", int'(d_pcm[5*DOW +: DOW]), shape(-dtot, 20, 4, 12, DOW));

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule